// File: doc/BRIEF.md
# Issue Queue Thread Share Controller

This block sets how many entries of a shared issue queue each hardware thread may hold, and admits or refuses per-thread entry allocations against those limits. A sharing mode input picks one of three rules: all threads may use the whole queue, the queue is split evenly among the active threads, or each active thread is capped at a percentage of the queue. The per-thread limits are registered and follow changes of the mode, the percentage and the active-thread mask one cycle later.

The block keeps an occupancy count per thread and a count of free queue entries. Every cycle it grants allocation pulses that fit both the thread's room and the free entries. Refused pulses are reported one cycle later. Release pulses return entries. An allocation and a release on the same thread in the same cycle cancel each other. The queue storage itself lives elsewhere.

Top module: `iq_share_ctrl`

## Requirements
- R1: With mode code 0, and with the spare code 3, every thread's limit becomes the queue depth, whatever the active mask is.
- R2: With mode code 1, every thread whose bit in the active mask is set gets the limit depth divided by the number of set mask bits, rounded down. The limit of a thread whose bit is clear keeps its value.
- R3: With mode code 2 and two or more active threads, each active thread gets the limit depth times the percentage, divided by 100 and rounded down. A percentage above 100 counts as 100. Inactive threads keep their limit.
- R4: With mode code 2 and exactly one active thread, that thread's limit becomes the full queue depth.
- R5: Under mode codes 1 and 2, an all-zero active mask leaves every limit unchanged.
- R6: The limits are registered. A change of the inputs shows at the limit outputs after the next rising clock edge, and every limit resets to the queue depth.
- R7: A thread's room is its limit minus its occupancy, or zero when the occupancy is at or above the limit. The thread's full flag is set exactly when its room is zero.
- R8: The queue-full flag is set when no queue entry is free. An accepted lone allocation takes one free entry, and a release on a thread with nonzero occupancy returns one. A release on a thread whose occupancy is zero is ignored.
- R9: A lone allocation is refused when its thread has no room, or when the free entries plus this cycle's lone releases are used up. When entries are scarce, lower-numbered threads are served first. A refusal raises that thread's reject bit for the one cycle after the request.
- R10: An allocation and a release on the same thread in one cycle, with nonzero occupancy, net out: the occupancy and the free count stay unchanged and nothing is refused, even when the thread has no room.
- R11: After reset all occupancies are zero, every room equals the depth, and no full or reject flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Sharing mode: 0 open, 1 even split, 2 percentage cap, 3 same as 0 |
| cap_pct | input | 7 | Percentage used by mode 2 |
| thread_active | input | NUM_THREADS | Active-thread mask |
| alloc_req | input | NUM_THREADS | Per-thread allocation pulse |
| release_req | input | NUM_THREADS | Per-thread release pulse |
| thread_limit | output | NUM_THREADS*CW | Per-thread limit, thread t in bits [t*CW +: CW] |
| thread_room | output | NUM_THREADS*CW | Per-thread entries still allowed |
| thread_full | output | NUM_THREADS | Thread room is zero |
| queue_full | output | 1 | No free queue entry |
| alloc_reject | output | NUM_THREADS | Allocation refused in the previous cycle |

## Verification
The hardest state to reach is a thread whose occupancy sits above a limit that has just shrunk. This happens when the queue is filled under open sharing and the mode is then switched to the even split or the percentage cap. The room must then clamp at zero, and a request that combines an allocation with a release must still net out. The bench builds this state on purpose: it fills the queue to the last entry under mode 0 and switches to mode 1 with one thread held above its new share. It also fills the queue to one free entry and then raises requests on two threads in the same cycle, to check the service order by thread number. A short random phase follows, checked against a cycle-level reference model.

// File: rtl/iq_share_pkg.sv
package iq_share_pkg;

    typedef enum logic [1:0] {
        SHARE_OPEN  = 2'd0,
        SHARE_SPLIT = 2'd1,
        SHARE_PCT   = 2'd2,
        SHARE_ALT   = 2'd3
    } share_mode_e;

    localparam int PCT_FULL = 100;

endpackage

// File: rtl/iq_share_limit.sv
module iq_share_limit
    import iq_share_pkg::*;
#(
    parameter int NT    = 4,
    parameter int DEPTH = 32,
    parameter int CW    = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             mode_sel,
    input  logic [6:0]             pct_in,
    input  logic [NT-1:0]          active_in,
    output logic [NT-1:0][CW-1:0]  limit_o
);

    localparam int AW = $clog2(NT + 1);
    localparam int PW = $clog2(DEPTH * PCT_FULL + 1);

    typedef struct packed {
        logic [NT-1:0][CW-1:0] lim;
    } lim_st_t;

    lim_st_t      st_d, st_q;
    share_mode_e  mode;
    logic [AW-1:0] act_cnt;
    logic [6:0]   pct_clip;
    logic [PW-1:0] pct_prod;
    logic [CW-1:0] pct_lim;
    logic [CW-1:0] split_tab [NT+1];

    assign mode = share_mode_e'(mode_sel);

    // even-split values for every possible active count, fixed at elaboration
    assign split_tab[0] = CW'(DEPTH);
    generate
        for (genvar k = 1; k <= NT; k++) begin : g_split
            assign split_tab[k] = CW'(DEPTH / k);
        end
    endgenerate

    always_comb begin
        act_cnt = '0;
        for (int t = 0; t < NT; t++) begin
            act_cnt = act_cnt + AW'(active_in[t]);
        end
    end

    assign pct_clip = (pct_in > 7'(PCT_FULL)) ? 7'(PCT_FULL) : pct_in;
    assign pct_prod = PW'(DEPTH) * PW'(pct_clip);
    assign pct_lim  = CW'(pct_prod / PW'(PCT_FULL));

    always_comb begin
        st_d = st_q;
        for (int t = 0; t < NT; t++) begin
            case (mode)
                SHARE_SPLIT: begin
                    if (active_in[t]) begin
                        st_d.lim[t] = split_tab[act_cnt];
                    end
                end
                SHARE_PCT: begin
                    if (active_in[t]) begin
                        st_d.lim[t] = (act_cnt == AW'(1)) ? CW'(DEPTH) : pct_lim;
                    end
                end
                default: begin
                    st_d.lim[t] = CW'(DEPTH);
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NT; t++) begin
                st_q.lim[t] <= CW'(DEPTH);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign limit_o = st_q.lim;

endmodule

// File: rtl/iq_share_admit.sv
module iq_share_admit #(
    parameter int NT    = 4,
    parameter int DEPTH = 32,
    parameter int CW    = 6
) (
    input  logic [NT-1:0]          alloc_in,
    input  logic [NT-1:0]          rel_in,
    input  logic [NT-1:0][CW-1:0]  occ_in,
    input  logic [NT-1:0][CW-1:0]  room_in,
    input  logic [CW-1:0]          gfree_in,
    output logic [NT-1:0]          take_o,
    output logic [NT-1:0]          drop_o,
    output logic [NT-1:0]          reject_o
);

    localparam int BW = $clog2(DEPTH + NT + 1);

    logic [NT-1:0] rel_ok;
    logic [BW-1:0] solo_rel_cnt;

    always_comb begin
        solo_rel_cnt = '0;
        for (int t = 0; t < NT; t++) begin
            rel_ok[t] = rel_in[t] && (occ_in[t] != '0);
            drop_o[t] = rel_ok[t] && !alloc_in[t];
            solo_rel_cnt = solo_rel_cnt + BW'(drop_o[t]);
        end
    end

    // serial grant chain: lower thread index sees the budget first
    always_comb begin
        logic [BW-1:0] budget;
        budget   = BW'(gfree_in) + solo_rel_cnt;
        take_o   = '0;
        reject_o = '0;
        for (int t = 0; t < NT; t++) begin
            if (alloc_in[t] && !rel_ok[t]) begin
                if ((room_in[t] != '0) && (budget != '0)) begin
                    take_o[t] = 1'b1;
                    budget    = budget - BW'(1);
                end else begin
                    reject_o[t] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/iq_share_occ.sv
module iq_share_occ #(
    parameter int NT    = 4,
    parameter int DEPTH = 32,
    parameter int CW    = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NT-1:0]          take_in,
    input  logic [NT-1:0]          drop_in,
    input  logic [NT-1:0]          reject_in,
    output logic [NT-1:0][CW-1:0]  occ_o,
    output logic [CW-1:0]          gfree_o,
    output logic [NT-1:0]          reject_o
);

    localparam int GW = CW + 1;

    typedef struct packed {
        logic [NT-1:0][CW-1:0] occ;
        logic [CW-1:0]         gfree;
        logic [NT-1:0]         rej;
    } occ_st_t;

    occ_st_t st_d, st_q;

    always_comb begin
        logic [GW-1:0] gsum;
        st_d = st_q;
        gsum = GW'(st_q.gfree);
        for (int t = 0; t < NT; t++) begin
            if (take_in[t]) begin
                st_d.occ[t] = st_q.occ[t] + CW'(1);
                gsum        = gsum - GW'(1);
            end else if (drop_in[t]) begin
                st_d.occ[t] = st_q.occ[t] - CW'(1);
                gsum        = gsum + GW'(1);
            end
        end
        st_d.gfree = CW'(gsum);
        st_d.rej   = reject_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.occ   <= '0;
            st_q.gfree <= CW'(DEPTH);
            st_q.rej   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign occ_o    = st_q.occ;
    assign gfree_o  = st_q.gfree;
    assign reject_o = st_q.rej;

endmodule

// File: rtl/iq_share_ctrl.sv
module iq_share_ctrl #(
    parameter int NUM_THREADS = 4,
    parameter int QUEUE_DEPTH = 32,
    localparam int CW = $clog2(QUEUE_DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                mode_sel,
    input  logic [6:0]                cap_pct,
    input  logic [NUM_THREADS-1:0]    thread_active,
    input  logic [NUM_THREADS-1:0]    alloc_req,
    input  logic [NUM_THREADS-1:0]    release_req,
    output logic [NUM_THREADS*CW-1:0] thread_limit,
    output logic [NUM_THREADS*CW-1:0] thread_room,
    output logic [NUM_THREADS-1:0]    thread_full,
    output logic                      queue_full,
    output logic [NUM_THREADS-1:0]    alloc_reject
);

    logic [NUM_THREADS-1:0][CW-1:0] lim_w;
    logic [NUM_THREADS-1:0][CW-1:0] occ_w;
    logic [NUM_THREADS-1:0][CW-1:0] room_w;
    logic [CW-1:0]                  gfree_w;
    logic [NUM_THREADS-1:0]         take_w, drop_w, rej_now_w, rej_q_w;

    iq_share_limit #(.NT(NUM_THREADS), .DEPTH(QUEUE_DEPTH), .CW(CW)) u_limit (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .pct_in    (cap_pct),
        .active_in (thread_active),
        .limit_o   (lim_w)
    );

    iq_share_admit #(.NT(NUM_THREADS), .DEPTH(QUEUE_DEPTH), .CW(CW)) u_admit (
        .alloc_in (alloc_req),
        .rel_in   (release_req),
        .occ_in   (occ_w),
        .room_in  (room_w),
        .gfree_in (gfree_w),
        .take_o   (take_w),
        .drop_o   (drop_w),
        .reject_o (rej_now_w)
    );

    iq_share_occ #(.NT(NUM_THREADS), .DEPTH(QUEUE_DEPTH), .CW(CW)) u_occ (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_in   (take_w),
        .drop_in   (drop_w),
        .reject_in (rej_now_w),
        .occ_o     (occ_w),
        .gfree_o   (gfree_w),
        .reject_o  (rej_q_w)
    );

    generate
        for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
            assign room_w[t] = (lim_w[t] > occ_w[t]) ? (lim_w[t] - occ_w[t]) : '0;
            assign thread_limit[t*CW +: CW] = lim_w[t];
            assign thread_room[t*CW +: CW]  = room_w[t];
            assign thread_full[t]           = (room_w[t] == '0);
        end
    endgenerate

    assign queue_full   = (gfree_w == '0);
    assign alloc_reject = rej_q_w;

endmodule

// File: rtl/iq_share_ctrl_chk.sv
module iq_share_ctrl_chk #(
    parameter int NUM_THREADS = 4,
    parameter int QUEUE_DEPTH = 32,
    parameter int CW = 6
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [1:0]                mode_sel,
    input logic [NUM_THREADS-1:0]    thread_active,
    input logic [NUM_THREADS-1:0]    alloc_req,
    input logic [NUM_THREADS-1:0]    release_req,
    input logic [NUM_THREADS*CW-1:0] thread_limit,
    input logic [NUM_THREADS*CW-1:0] thread_room,
    input logic [NUM_THREADS-1:0]    thread_full,
    input logic                      queue_full,
    input logic [NUM_THREADS-1:0]    alloc_reject
);

    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_sel == 2'd1 || mode_sel == 2'd2) && thread_active == '0) |=> $stable(thread_limit));

    a_r8_full_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req == '0 && release_req == '0) |=> $stable(queue_full));

    generate
        for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
            a_r1_open_limit: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_sel == 2'd0 || mode_sel == 2'd3) |=> (thread_limit[t*CW +: CW] == CW'(QUEUE_DEPTH)));

            a_r9_thread_no_room: assert property (@(posedge clk) disable iff (!rst_n)
                (thread_full[t] && alloc_req[t] && !release_req[t]) |=> alloc_reject[t]);

            a_r9_queue_no_room: assert property (@(posedge clk) disable iff (!rst_n)
                (queue_full && alloc_req[t] && release_req == '0) |=> alloc_reject[t]);

            a_r9_reject_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
                !alloc_req[t] |=> !alloc_reject[t]);

            a_r10_net_no_reject: assert property (@(posedge clk) disable iff (!rst_n)
                (alloc_req[t] && release_req[t] &&
                 (thread_room[t*CW +: CW] < thread_limit[t*CW +: CW])) |=> !alloc_reject[t]);
        end
    endgenerate

endmodule

bind iq_share_ctrl iq_share_ctrl_chk #(
    .NUM_THREADS (NUM_THREADS),
    .QUEUE_DEPTH (QUEUE_DEPTH),
    .CW          (CW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_sel      (mode_sel),
    .thread_active (thread_active),
    .alloc_req     (alloc_req),
    .release_req   (release_req),
    .thread_limit  (thread_limit),
    .thread_room   (thread_room),
    .thread_full   (thread_full),
    .queue_full    (queue_full),
    .alloc_reject  (alloc_reject)
);

// File: tb/iq_share_ctrl_test.sv
module iq_share_ctrl_test;

    localparam int NT = 4;
    localparam int DEPTH = 32;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [NT*CW-1:0] lim;
        logic [NT*CW-1:0] room;
        logic [NT-1:0]    full;
        logic             qf;
        logic [NT-1:0]    rej;
    } obs_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode_sel = '0;
    logic [6:0] cap_pct = '0;
    logic [NT-1:0] thread_active = '0;
    logic [NT-1:0] alloc_req = '0;
    logic [NT-1:0] release_req = '0;
    logic [NT*CW-1:0] thread_limit, thread_room;
    logic [NT-1:0] thread_full, alloc_reject;
    logic queue_full;

    int n_cmp = 0;
    int n_bad = 0;

    obs_t  exp_q [$];
    string tag_q [$];

    int m_lim [NT];
    int m_occ [NT];
    int m_gfree;

    always #4 clk = ~clk;

    iq_share_ctrl #(.NUM_THREADS(NT), .QUEUE_DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cap_pct(cap_pct),
        .thread_active(thread_active), .alloc_req(alloc_req), .release_req(release_req),
        .thread_limit(thread_limit), .thread_room(thread_room), .thread_full(thread_full),
        .queue_full(queue_full), .alloc_reject(alloc_reject)
    );

    function automatic obs_t sample_now();
        obs_t o;
        o.lim = thread_limit; o.room = thread_room; o.full = thread_full;
        o.qf = queue_full; o.rej = alloc_reject;
        return o;
    endfunction

    task automatic compare(input obs_t act, input obs_t exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: lim %h/%h room %h/%h full %b/%b qfull %b/%b rej %b/%b (actual/expected)",
                     tag, act.lim, exp.lim, act.room, exp.room, act.full, exp.full,
                     act.qf, exp.qf, act.rej, exp.rej);
        end
    endtask

    // driver: apply one cycle of stimulus and push the expected post-edge view
    task automatic step(input logic [1:0] md, input int pct, input logic [NT-1:0] act,
                        input logic [NT-1:0] al, input logic [NT-1:0] rl, input string tag);
        int cnt, pc, thr, budget, solo, room;
        int nlim [NT];
        bit rv;
        obs_t e;
        @(negedge clk);
        mode_sel = md; cap_pct = 7'(pct); thread_active = act;
        alloc_req = al; release_req = rl;
        cnt = 0;
        for (int t = 0; t < NT; t++) cnt += act[t];
        pc = (pct > 100) ? 100 : pct;
        thr = (DEPTH * pc) / 100;
        for (int t = 0; t < NT; t++) begin
            nlim[t] = m_lim[t];
            if (md == 2'd1) begin
                if (act[t]) nlim[t] = DEPTH / cnt;
            end else if (md == 2'd2) begin
                if (act[t]) nlim[t] = (cnt == 1) ? DEPTH : thr;
            end else begin
                nlim[t] = DEPTH;
            end
        end
        solo = 0;
        for (int t = 0; t < NT; t++) if (rl[t] && m_occ[t] > 0 && !al[t]) solo++;
        budget = m_gfree + solo;
        e.rej = '0;
        for (int t = 0; t < NT; t++) begin
            rv = rl[t] && (m_occ[t] > 0);
            room = (m_lim[t] > m_occ[t]) ? m_lim[t] - m_occ[t] : 0;
            if (al[t] && rv) begin
            end else if (al[t]) begin
                if (room > 0 && budget > 0) begin
                    m_occ[t]++; m_gfree--; budget--;
                end else begin
                    e.rej[t] = 1'b1;
                end
            end else if (rv) begin
                m_occ[t]--; m_gfree++;
            end
        end
        for (int t = 0; t < NT; t++) begin
            m_lim[t] = nlim[t];
            room = (m_lim[t] > m_occ[t]) ? m_lim[t] - m_occ[t] : 0;
            e.lim[t*CW +: CW]  = CW'(m_lim[t]);
            e.room[t*CW +: CW] = CW'(room);
            e.full[t] = (room == 0);
        end
        e.qf = (m_gfree == 0);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: compare each expected item just after the edge that produces it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                compare(sample_now(), exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog R11: actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        obs_t r;
        for (int t = 0; t < NT; t++) begin m_lim[t] = DEPTH; m_occ[t] = 0; end
        m_gfree = DEPTH;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 and R6: reset values
        for (int t = 0; t < NT; t++) begin
            r.lim[t*CW +: CW] = CW'(DEPTH); r.room[t*CW +: CW] = CW'(DEPTH);
        end
        r.full = '0; r.qf = 1'b0; r.rej = '0;
        compare(sample_now(), r, "R11 reset");

        step(2'd0, 0, 4'hF, 4'h0, 4'h0, "R1 open");
        for (int i = 0; i < 8; i++) step(2'd0, 0, 4'hF, 4'hF, 4'h0, "R8 fill");
        step(2'd0, 0, 4'hF, 4'h1, 4'h0, "R9 queue full reject");
        step(2'd0, 0, 4'hF, 4'h1, 4'h2, "R9 reuse of lone release");
        step(2'd3, 0, 4'h0, 4'h0, 4'h0, "R1 spare code");
        step(2'd1, 0, 4'hF, 4'h0, 4'h0, "R2 split four / R7 clamp");
        step(2'd1, 0, 4'hF, 4'h1, 4'h0, "R7 no room reject");
        step(2'd1, 0, 4'hF, 4'h1, 4'h1, "R10 net out");
        for (int i = 0; i < 10; i++) step(2'd1, 0, 4'hF, 4'h0, 4'hF, "R8 drain and idle release");
        step(2'd1, 0, 4'h3, 4'h0, 4'h0, "R2 split two");
        step(2'd1, 0, 4'h7, 4'h0, 4'h0, "R2 split three");
        step(2'd1, 0, 4'h0, 4'h0, 4'h0, "R5 split none");
        step(2'd2, 30, 4'hF, 4'h0, 4'h0, "R3 thirty percent");
        step(2'd2, 127, 4'hF, 4'h0, 4'h0, "R3 percent clip");
        step(2'd2, 50, 4'hF, 4'h0, 4'h0, "R3 half");
        step(2'd2, 50, 4'h4, 4'h0, 4'h0, "R4 single thread");
        step(2'd2, 50, 4'h0, 4'h0, 4'h0, "R5 percent none");
        step(2'd2, 0, 4'hF, 4'h0, 4'h0, "R3 zero percent");
        step(2'd2, 0, 4'hF, 4'hF, 4'h0, "R9 zero limit reject");
        step(2'd0, 0, 4'hF, 4'h0, 4'h0, "R6 back to open");
        for (int i = 0; i < 7; i++) step(2'd0, 0, 4'hF, 4'hF, 4'h0, "R8 refill");
        step(2'd0, 0, 4'hF, 4'h7, 4'h0, "R8 one left");
        step(2'd0, 0, 4'hF, 4'hA, 4'h0, "R9 index priority");
        for (int i = 0; i < 400; i++) begin
            step(2'($urandom_range(0, 3)), int'($urandom_range(0, 127)),
                 NT'($urandom), NT'($urandom), NT'($urandom), "R2 R3 R8 R9 random");
        end
        step(2'd0, 0, 4'hF, 4'h0, 4'h0, "R1 final");
        repeat (3) @(posedge clk);
        #3;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule